// File: doc/BRIEF.md
# DRAM Initialization and Refresh Sequencer

This block brings an asynchronous EDO DRAM out of power-up and keeps its contents alive afterwards. Out of reset it keeps every control strobe inactive through a settling pause whose length is set in nanoseconds and converted to clocks from the clock-period parameter. It then runs a burst of wake-up refresh cycles and raises a ready indication. From then on it schedules one CAS-before-RAS refresh per interval. The interval is derived from the retention window, the number of rows and the clock period, so every row is refreshed in time. The memory's internal row counter picks the row, so the block drives no address.

The sequencer shares the RAS#, CAS# and WE# strobes with an access engine. When a refresh is due it raises a bus request, and it drives the strobes only once the access engine has granted the bus. It keeps the request high until the last precharge of its burst is over. If a pending refresh goes without a grant for longer than a programmable slack, the block treats retention as lost. It drops ready, flags the overdue condition and, on the next grant, repeats the full wake-up burst before it declares the memory ready again.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset until `ceil(PAUSE_NS*1000/CLK_PERIOD_PS)` clock edges have passed, `rasN` and `casN` stay high, `busReq` stays low and `memReady` stays low.
- R2: After the pause, the first granted request contains exactly `WAKE_CYCLES` refresh cycles back to back. `memReady` is high when the request drops.
- R3: In every refresh cycle `casN` is low for at least `CSR_CLK` cycles before `rasN` falls, and `weN` is high when `rasN` falls.
- R4: `rasN` stays low for exactly `TRAS_CLK` cycles, and `casN` returns high while `rasN` is still low. Both strobes are high for at least `TRP_CLK` cycles between the end of one RAS pulse and the next fall of `casN`.
- R5: Once ready, with the grant given immediately, consecutive single refreshes start exactly `floor(RETENTION_NS*1000/CLK_PERIOD_PS/REFRESH_ROWS)` cycles apart.
- R6: A strobe is low only while `busOwned` is high, which needs a prior `busGrant` while requesting. `busReq` stays high across the whole burst, and a normal due refresh is a single cycle.
- R7: A refresh pending for `SLACK_CLK` cycles without the bus raises `refreshOverdue` and drops `memReady`. A grant that comes earlier gives one refresh and no flag.
- R8: After an overdue condition, the next granted request holds `WAKE_CYCLES` refresh cycles. At its end `memReady` is high again and `refreshOverdue` is low.
- R9: If the slack runs out in the very cycle the grant arrives, the burst is the full wake-up burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busGrant | input | 1 | Access engine hands the strobes to the sequencer |
| busReq | output | 1 | Sequencer asks for the strobes |
| busOwned | output | 1 | Sequencer is driving a refresh cycle |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, held high during refresh |
| memReady | output | 1 | Memory initialized and within retention |
| refreshOverdue | output | 1 | Retention deadline missed, wake-up burst outstanding |

## Verification
The refresh deadline running out and the bus grant arriving can land on the same clock edge. The first wants a full wake-up burst and the second starts a burst whose length is fixed at that edge. The bench withholds the grant after a request and releases it after a delay that sweeps across the slack boundary, so that one delay hits the coincident edge exactly. Each request window is judged on its own: a window in which `refreshOverdue` was seen must contain the full wake-up burst, a window without it exactly one refresh, and both must end with `memReady` high and the flag clear.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_REQ,
    ST_CSR,
    ST_RAS,
    ST_PRE,
    ST_IDLE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseClr;
    logic burstLoad;
    logic burstDec;
    logic burstEnd;
    logic owning;
  } seqCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic pauseDone;
    logic csrDone;
    logic rasDone;
    logic preDone;
    logic phaseZero;
    logic lastCycle;
    logic wantRefresh;
    logic ready;
    logic overdueFlag;
  } seqStat_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refseq_dp.sv
module refseq_dp
  import refseq_pkg::*;
#(
  parameter int PAUSE_CLK   = 25000,
  parameter int CSR_CLK     = 1,
  parameter int TRAS_CLK    = 12,
  parameter int TRP_CLK     = 8,
  parameter int REFI_CLK    = 3906,
  parameter int SLACK_CLK   = 1000,
  parameter int WAKE_CYCLES = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  seqCtl_t  ctl,
  output seqStat_t stat
);

  localparam int PH_MAX = maxOf(maxOf(PAUSE_CLK, CSR_CLK), maxOf(TRAS_CLK, TRP_CLK));
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int BL_W   = $clog2(WAKE_CYCLES + 1);
  localparam int IV_W   = $clog2(REFI_CLK + 1);
  localparam int SL_W   = $clog2(SLACK_CLK + 1);

  logic [PH_W-1:0] phaseCnt;
  logic [BL_W-1:0] burstLeft;
  logic [IV_W-1:0] intervalCnt;
  logic [SL_W-1:0] slackCnt;
  logic pending, needWake, overdueFlag, memReady;
  logic refTick, overdueNow;

  // phase timer shared by pause, setup, active and precharge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             phaseCnt <= '0;
    else if (ctl.phaseClr) phaseCnt <= '0;
    else                   phaseCnt <= phaseCnt + 1'b1;
  end

  assign refTick    = !needWake && (intervalCnt == IV_W'(REFI_CLK - 1));
  assign overdueNow = pending && !ctl.owning && (slackCnt == SL_W'(SLACK_CLK - 1));

  // refresh cycles left in the current request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) burstLeft <= '0;
    else if (ctl.burstLoad)
      burstLeft <= (needWake || overdueNow) ? BL_W'(WAKE_CYCLES) : BL_W'(1);
    else if (ctl.burstDec)
      burstLeft <= burstLeft - 1'b1;
  end

  // retention interval, held while a wake-up burst is outstanding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         intervalCnt <= '0;
    else if (needWake) intervalCnt <= '0;
    else if (refTick)  intervalCnt <= '0;
    else               intervalCnt <= intervalCnt + 1'b1;
  end

  // deadline counter for a pending refresh not yet on the bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           slackCnt <= '0;
    else if (!pending || ctl.owning)     slackCnt <= '0;
    else if (overdueNow)                 slackCnt <= '0;
    else                                 slackCnt <= slackCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pending <= 1'b0;
    else if (overdueNow)   pending <= 1'b0;
    else if (refTick)      pending <= 1'b1;
    else if (ctl.burstEnd) pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             needWake <= 1'b1;
    else if (overdueNow)   needWake <= 1'b1;
    else if (ctl.burstEnd) needWake <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             overdueFlag <= 1'b0;
    else if (overdueNow)   overdueFlag <= 1'b1;
    else if (ctl.burstEnd) overdueFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             memReady <= 1'b0;
    else if (overdueNow)   memReady <= 1'b0;
    else if (ctl.burstEnd) memReady <= 1'b1;
  end

  always_comb begin
    stat.pauseDone   = (phaseCnt == PH_W'(PAUSE_CLK - 1));
    stat.csrDone     = (phaseCnt == PH_W'(CSR_CLK - 1));
    stat.rasDone     = (phaseCnt == PH_W'(TRAS_CLK - 1));
    stat.preDone     = (phaseCnt == PH_W'(TRP_CLK - 1));
    stat.phaseZero   = (phaseCnt == '0);
    stat.lastCycle   = (burstLeft == BL_W'(1));
    stat.wantRefresh = pending || needWake;
    stat.ready       = memReady;
    stat.overdueFlag = overdueFlag;
  end

  // a new interval must never find the previous refresh still waiting
  assert_no_lost_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    refTick |-> !pending);

  // a missed deadline takes ready away on the next edge
  assert_overdue_drops_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    overdueNow |=> (!memReady && overdueFlag));

  // the flag clears only together with ready coming back
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overdueFlag) |-> memReady);

endmodule

// File: rtl/refseq_ctrl.sv
module refseq_ctrl
  import refseq_pkg::*;
#(
  parameter int TRAS_CLK = 12
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     busGrant,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     busReq,
  output logic     busOwned,
  output logic     rasN,
  output logic     casN,
  output logic     weN
);

  localparam int RL_W = $clog2(TRAS_CLK + 2);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PAUSE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_PAUSE: if (stat.pauseDone)   nextState = ST_REQ;
      ST_REQ:   if (busGrant)         nextState = ST_CSR;
      ST_CSR:   if (stat.csrDone)     nextState = ST_RAS;
      ST_RAS:   if (stat.rasDone)     nextState = ST_PRE;
      ST_PRE:   if (stat.preDone)     nextState = stat.lastCycle ? ST_IDLE : ST_CSR;
      ST_IDLE:  if (stat.wantRefresh) nextState = ST_REQ;
      default:                        nextState = ST_PAUSE;
    endcase
  end

  always_comb begin
    ctl.phaseClr  = (nextState != state);
    ctl.burstLoad = (state == ST_REQ) && busGrant;
    ctl.burstDec  = (state == ST_PRE) && stat.preDone && !stat.lastCycle;
    ctl.burstEnd  = (state == ST_PRE) && stat.preDone && stat.lastCycle;
    ctl.owning    = (state == ST_CSR) || (state == ST_RAS) || (state == ST_PRE);
  end

  assign busOwned = ctl.owning;
  assign busReq   = ctl.owning || (state == ST_REQ);
  assign rasN     = !(state == ST_RAS);
  assign casN     = !((state == ST_CSR) || ((state == ST_RAS) && stat.phaseZero));
  assign weN      = 1'b1;

  // checker counter: length of the current RAS pulse
  logic [RL_W-1:0] rasLowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rasLowRun <= '0;
    else if (rasN) rasLowRun <= '0;
    else           rasLowRun <= rasLowRun + 1'b1;
  end

  assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAUSE) |-> (rasN && casN && !busReq && !stat.ready));

  assert_ready_after_burst_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat.ready) |-> $past(state == ST_PRE));

  assert_cas_before_ras_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN) && weN));

  assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (rasLowRun == RL_W'(TRAS_CLK)));

  assert_grant_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOwned) |-> $past(busGrant && busReq));

  assert_flag_not_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    stat.overdueFlag |-> !stat.ready);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import refseq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned PAUSE_NS      = 100000,
  parameter int unsigned RETENTION_NS  = 64000000,
  parameter int unsigned REFRESH_ROWS  = 4096,
  parameter int          WAKE_CYCLES   = 8,
  parameter int          CSR_CLK       = 1,
  parameter int          TRAS_CLK      = 12,
  parameter int          TRP_CLK       = 8,
  parameter int          SLACK_CLK     = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic busGrant,
  output logic busReq,
  output logic busOwned,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic memReady,
  output logic refreshOverdue
);

  localparam longint unsigned PAUSE_PS = longint'(PAUSE_NS) * 64'd1000;
  localparam longint unsigned RET_PS   = longint'(RETENTION_NS) * 64'd1000;
  localparam int PAUSE_CLK = int'((PAUSE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS);
  localparam int REFI_CLK  = int'(RET_PS / CLK_PERIOD_PS / REFRESH_ROWS);

  seqCtl_t  ctl;
  seqStat_t stat;

  refseq_ctrl #(
    .TRAS_CLK(TRAS_CLK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .stat(stat), .ctl(ctl),
    .busReq(busReq), .busOwned(busOwned), .rasN(rasN), .casN(casN), .weN(weN)
  );

  refseq_dp #(
    .PAUSE_CLK(PAUSE_CLK), .CSR_CLK(CSR_CLK), .TRAS_CLK(TRAS_CLK),
    .TRP_CLK(TRP_CLK), .REFI_CLK(REFI_CLK), .SLACK_CLK(SLACK_CLK),
    .WAKE_CYCLES(WAKE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat)
  );

  assign memReady       = stat.ready;
  assign refreshOverdue = stat.overdueFlag;

endmodule

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;

  localparam int PERIOD_PS = 4000;
  localparam int PAUSE_NS  = 400;
  localparam int RET_NS    = 3840;
  localparam int ROWS      = 16;
  localparam int WAKE      = 8;
  localparam int CSR       = 1;
  localparam int TRAS      = 3;
  localparam int TRP       = 2;
  localparam int SLACK     = 20;
  localparam int PAUSE_EXP = (PAUSE_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int REFI_EXP  = RET_NS * 1000 / PERIOD_PS / ROWS;

  typedef struct {
    int    n;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allow = 1'b1;
  logic busGrant, busReq, busOwned, rasN, casN, weN, memReady, refreshOverdue;

  assign busGrant = busReq && allow;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .CLK_PERIOD_PS(PERIOD_PS), .PAUSE_NS(PAUSE_NS), .RETENTION_NS(RET_NS),
    .REFRESH_ROWS(ROWS), .WAKE_CYCLES(WAKE), .CSR_CLK(CSR),
    .TRAS_CLK(TRAS), .TRP_CLK(TRP), .SLACK_CLK(SLACK)
  ) dut (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .busReq(busReq),
    .busOwned(busOwned), .rasN(rasN), .casN(casN), .weN(weN),
    .memReady(memReady), .refreshOverdue(refreshOverdue)
  );

  int checks = 0;
  int errors = 0;
  int doneBursts = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor state
  int  cyc = 0;
  bit  prevRas = 1, prevCas = 1, prevReq = 0;
  int  casLowRun = 0, rasLowRun = 0, highRun = 0;
  bit  firstRasDone = 0, firstReqSeen = 0, casRoseInRas = 0;
  bit  inWin = 0, ovSeen = 0, prevSingleValid = 0;
  int  winCnt = 0, winWait = 0, thisRasFall = 0, prevSingleRas = 0;
  int  illegal = 0;

  always @(negedge clk) begin
    if (rstN) begin
      expItem_t it;
      cyc++;
      if ((!rasN || !casN) && !busOwned) illegal++;
      if (busReq && !prevReq) begin
        if (!firstReqSeen) begin
          check(cyc >= PAUSE_EXP, "R1 pause length", cyc, PAUSE_EXP);
          firstReqSeen = 1;
        end
        inWin = 1; winCnt = 0; winWait = 0; ovSeen = 0;
      end
      if (inWin) begin
        if (busReq && !busOwned) winWait++;
        if (refreshOverdue) ovSeen = 1;
      end
      if (!casN && prevCas && firstRasDone)
        check(highRun >= TRP, "R4 precharge", highRun, TRP);
      if (!rasN && prevRas) begin
        check(!casN && casLowRun >= CSR, "R3 cas lead", casLowRun, CSR);
        check(weN == 1'b1, "R3 we high", int'(weN), 1);
        winCnt++;
        thisRasFall = cyc;
        casRoseInRas = 0;
      end
      if (!rasN && casN) casRoseInRas = 1;
      if (rasN && !prevRas) begin
        check(rasLowRun == TRAS, "R4 ras width", rasLowRun, TRAS);
        check(casRoseInRas, "R4 cas rises in ras", int'(casRoseInRas), 1);
        firstRasDone = 1;
      end
      if (!busReq && prevReq && inWin) begin
        if (expQ.size() == 0) begin
          it.n = -1; it.tag = "R6 unexpected burst";
        end else begin
          it = expQ.pop_front();
        end
        if (it.n == 0) it.n = ovSeen ? WAKE : 1;
        check(winCnt == it.n, {it.tag, " burst length"}, winCnt, it.n);
        check(memReady == 1'b1, {it.tag, " ready after burst"}, int'(memReady), 1);
        check(refreshOverdue == 1'b0, {it.tag, " flag cleared"}, int'(refreshOverdue), 0);
        if (winCnt == 1 && winWait == 1 && !ovSeen) begin
          if (prevSingleValid)
            check(thisRasFall - prevSingleRas == REFI_EXP, "R5 interval",
                  thisRasFall - prevSingleRas, REFI_EXP);
          prevSingleRas = thisRasFall;
          prevSingleValid = 1;
        end else begin
          prevSingleValid = 0;
        end
        doneBursts++;
        inWin = 0;
      end
      casLowRun = !casN ? casLowRun + 1 : 0;
      rasLowRun = !rasN ? rasLowRun + 1 : 0;
      highRun   = (rasN && casN) ? highRun + 1 : 0;
      prevRas = rasN; prevCas = casN; prevReq = busReq;
    end
  end

  task automatic waitBursts(input int n);
    while (doneBursts < n) @(negedge clk);
  endtask

  task automatic waitReq();
    while (!busReq) @(negedge clk);
  endtask

  task automatic push(input int n, input string tag);
    expItem_t it;
    it.n = n; it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin
    int target;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(rasN && casN && weN, "R1 reset strobes", int'({rasN, casN, weN}), 7);
    check(!busReq && !memReady, "R1 reset req/ready", int'({busReq, memReady}), 0);
    push(WAKE, "R2");
    rstN = 1'b1;
    waitBursts(1);
    // routine refreshes with immediate grant
    for (int i = 0; i < 4; i++) push(1, "R6");
    waitBursts(5);
    // grant held back but inside the slack
    allow = 1'b0;
    push(1, "R7");
    waitReq();
    repeat (SLACK - 6) @(negedge clk);
    check(!refreshOverdue && memReady, "R7 within slack",
          int'({refreshOverdue, memReady}), 1);
    allow = 1'b1;
    waitBursts(6);
    // grant held back past the slack
    allow = 1'b0;
    push(WAKE, "R8");
    waitReq();
    repeat (SLACK + 4) @(negedge clk);
    check(refreshOverdue == 1'b1, "R7 overdue flag", int'(refreshOverdue), 1);
    check(memReady == 1'b0, "R7 ready dropped", int'(memReady), 0);
    check(rasN && casN, "R6 idle without grant", int'({rasN, casN}), 3);
    allow = 1'b1;
    waitBursts(7);
    check(memReady == 1'b1, "R8 ready restored", int'(memReady), 1);
    // sweep grant delay across the deadline edge
    target = 7;
    for (int d = SLACK - 4; d <= SLACK; d++) begin
      allow = 1'b0;
      push(0, "R9");
      waitReq();
      repeat (d) @(negedge clk);
      allow = 1'b1;
      target++;
      waitBursts(target);
    end
    check(illegal == 0, "R6 strobes only when owned", illegal, 0);
    check(expQ.size() == 0, "R6 all bursts seen", expQ.size(), 0);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", doneBursts, -1);
    finishRun();
  end

endmodule